// File: doc/BRIEF.md
# Byte-Strobed Multiplexed-Address DRAM Core Control

This block is a clock-sampled model of the control section inside a 256K x 16 dynamic memory whose data word is split into two byte lanes. Each lane has its own column strobe. On every rising clock edge the block samples the row strobe, the low-lane and high-lane column strobes, the write enable, the output enable and a 9-bit address bus that carries the row half and then the column half of the cell address. From the edges it sees, it latches addresses, starts reads and writes, and drives per-lane output enables and write strobes into a small backing store of parameterised size. It also recognises a refresh-only cycle, in which the column strobe is already low when the row strobe falls, and steps an internal row counter for it.

All timing is counted in clock cycles. An edge on an input is seen at the first rising clock edge after it occurs. Read data and output enables are registered, so they change at the edge that launches the read. The backing store folds each row and each column onto a few index bits by XOR-ing the bits together. Cell contents persist until they are written again.

Top module: `bytelane_dram_core`

## Requirements
- R1: At a clock edge where `ras_n` is seen falling, `addr` is latched as the row. At an edge where the merged column strobe is seen falling during an access, `addr` is the column, and that column stays latched for later OE-launched reads and late writes. A row and a column select one storage word.
- R2: The merged column strobe is low while either `lcas_n` or `ucas_n` is low. It returns high only when both are high. A fall of either lane from the both-high state is a column strobe fall.
- R3: Lane 0 (bits 7:0) follows `lcas_n` and lane 1 (bits 15:8) follows `ucas_n`. Lane enables are bit 0 and bit 1 of `dq_oe` and of the internal write mask. They are taken from the strobes that are low at the edge that launches the operation.
- R4: A read is launched at the later of the column strobe fall and the `oe_n` fall, while `we_n` is high and a normal access is open. After that edge, `dq_out` holds the addressed word and `dq_oe` holds the launching lane mask.
- R5: A write is launched at the later of the column strobe fall and the `we_n` fall. The data written is `din` as sampled at the earlier of the two falls, or at that same edge when both fall together or when `we_n` stayed low from the previous column cycle.
- R6: Read output stays enabled when the column strobe rises. It is withdrawn at the next column strobe fall unless that fall launches a new read.
- R7: During one open row, new columns can be read or written repeatedly by toggling the column strobes with new addresses.
- R8: If the merged column strobe was already low at the edge before the one where `ras_n` is seen falling, the cycle is refresh-only. `addr` is ignored, no read or write happens while it lasts, and `dq_oe` stays 2'b00.
- R9: `rfsh_row` shows the internal refresh row counter. It increases by one at the edge where a refresh-only cycle ends (`ras_n` seen rising) and wraps from 511 to 0.
- R10: `dq_oe` is 2'b00 after any edge that samples `oe_n` high, and after any edge that samples `ras_n`, `lcas_n` and `ucas_n` all high. An `oe_n` rise cancels the held read, so output returns only through a new launch.
- R11: Reset is synchronous and active low. Held for one edge, it gives `dq_oe` = 2'b00 and `rfsh_row` = 0, and it treats every strobe as previously inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Low-lane column strobe, active low |
| ucas_n | input | 1 | High-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (9) | Multiplexed row/column address |
| din | input | 2*LANE_W (16) | Write data |
| dq_out | output | 2*LANE_W (16) | Registered read data |
| dq_oe | output | 2 | Per-lane output drive enable |
| rfsh_row | output | ADDR_W (9) | Internal refresh row counter |

## Verification
A wrong latched row or column shows up at the first read of a word written through another address path, in the cycle after the read is launched. The bench therefore writes by early, late and WE-first ordering and reads each word back. A wrong merged strobe or lane capture shows on `dq_oe` in the edge after the strobes change, as a lane that should stay dark or a read that never starts. A misdetected refresh is caught in two ways: an attempted write inside the refresh cycle is read back, and `rfsh_row` is compared after every refresh, including across the 511-to-0 wrap.

// File: rtl/bytelane_dram_pkg.sv
// Package: shared constants and types for the byte-lane DRAM core.
// Assumes exactly two byte lanes, one per column strobe pin.
package bytelane_dram_pkg;
    localparam int LANES = 2;
    typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/bytelane_strobe_edges.sv
// Module: samples the active-low control strobes once per clock and reports
// the edges seen between the previous and the current sample. Merges the two
// lane column strobes into one (low while either is low).
// Assumes inputs are already synchronous to clk.
module bytelane_strobe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic lcas_n,
    input  logic ucas_n,
    input  logic we_n,
    input  logic oe_n,
    output logic cas_n,
    output logic cas_was_low,
    output logic ras_fall,
    output logic ras_rise,
    output logic cas_fall,
    output logic we_fall,
    output logic oe_fall,
    output logic oe_rise,
    output logic oe_q
);
    logic ras_q, cas_q, we_q;

    // Merged strobe: first lane to fall asserts, last lane to rise releases.
    assign cas_n = lcas_n & ucas_n;

    // History of each strobe; reset treats all as inactive (high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
            oe_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
            oe_q  <= oe_n;
        end
    end

    // Edge flags from history versus the current sample.
    assign ras_fall    = ras_q & ~ras_n;
    assign ras_rise    = ~ras_q & ras_n;
    assign cas_fall    = cas_q & ~cas_n;
    assign we_fall     = we_q & ~we_n;
    assign oe_fall     = oe_q & ~oe_n;
    assign oe_rise     = ~oe_q & oe_n;
    assign cas_was_low = ~cas_q;
endmodule

// File: rtl/bytelane_row_col_unit.sv
// Module: holds the open row and the current column, and decides at each row
// strobe fall whether the cycle is a normal access or a refresh-only cycle.
// In refresh the row comes from an internal counter that steps when the cycle
// ends. Assumes ras_fall and ras_rise are never both set.
module bytelane_row_col_unit #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    input  logic              cas_was_low,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_open,
    output logic              rfsh_busy,
    output logic [ADDR_W-1:0] row_q,
    output logic [ADDR_W-1:0] col_eff,
    output logic [ADDR_W-1:0] rfsh_cnt
);
    logic [ADDR_W-1:0] col_q;

    // Row/refresh decision at row strobe edges, column capture at strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_open  <= 1'b0;
            rfsh_busy <= 1'b0;
            row_q     <= '0;
            col_q     <= '0;
            rfsh_cnt  <= '0;
        end else begin
            if (ras_fall) begin
                if (cas_was_low) begin
                    rfsh_busy <= 1'b1;
                    row_q     <= rfsh_cnt;
                end else begin
                    acc_open  <= 1'b1;
                    row_q     <= addr;
                end
            end else if (ras_rise) begin
                acc_open <= 1'b0;
                if (rfsh_busy) begin
                    rfsh_busy <= 1'b0;
                    rfsh_cnt  <= rfsh_cnt + 1'b1;
                end
            end
            if (cas_fall && acc_open) begin
                col_q <= addr;
            end
        end
    end

    // Column seen by this edge: live bus on a strobe fall, else the latch.
    assign col_eff = cas_fall ? addr : col_q;
endmodule

// File: rtl/bytelane_lane_store.sv
// Module: backing storage, one independent byte array per lane so that each
// lane strobe writes only its own byte. Combinational read, synchronous write.
// Contents are not reset.
module bytelane_lane_store #(
    parameter int LANE_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic                                 clk,
    input  bytelane_dram_pkg::lane_mask_t        wr_mask,
    input  logic [IDX_W-1:0]                     idx,
    input  logic [bytelane_dram_pkg::LANES*LANE_W-1:0] wdata,
    output logic [bytelane_dram_pkg::LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    for (genvar g = 0; g < bytelane_dram_pkg::LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Byte write for this lane when its strobe bit is set.
        always_ff @(posedge clk) begin
            if (wr_mask[g]) begin
                cells[idx] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[idx];
    end
endmodule

// File: rtl/bytelane_dram_core.sv
// Module: top of the byte-lane DRAM control model. Launches reads at the later
// of column strobe fall and OE fall (WE high) and writes at the later of
// column strobe fall and WE fall, with write data from the earlier edge.
// Holds read output across the column strobe rise (extended data out) until
// the next fall. Assumes synchronous inputs sampled at clk; row and column
// are XOR-folded onto ROW_KEEP and COL_KEEP storage index bits.
module bytelane_dram_core #(
    parameter int ADDR_W   = 9,
    parameter int LANE_W   = 8,
    parameter int ROW_KEEP = 3,
    parameter int COL_KEEP = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ras_n,
    input  logic                  lcas_n,
    input  logic                  ucas_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*LANE_W-1:0]   din,
    output logic [2*LANE_W-1:0]   dq_out,
    output logic [1:0]            dq_oe,
    output logic [ADDR_W-1:0]     rfsh_row
);
    import bytelane_dram_pkg::*;

    localparam int DATA_W = LANES * LANE_W;
    localparam int IDX_W  = ROW_KEEP + COL_KEEP;

    logic cas_n, cas_was_low, ras_fall, ras_rise, cas_fall;
    logic we_fall, oe_fall, oe_rise, oe_q;
    logic acc_open, rfsh_busy;
    logic [ADDR_W-1:0] row_q, col_eff;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rdata, wcap, wr_data;
    logic              wfirst;
    lane_mask_t        lanes_live, wr_mask, lane_drv;
    logic              rd_go, wr_cas, wr_late, wr_go, cas_low;

    bytelane_strobe_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n      (ras_n),
        .lcas_n     (lcas_n),
        .ucas_n     (ucas_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .cas_n      (cas_n),
        .cas_was_low(cas_was_low),
        .ras_fall   (ras_fall),
        .ras_rise   (ras_rise),
        .cas_fall   (cas_fall),
        .we_fall    (we_fall),
        .oe_fall    (oe_fall),
        .oe_rise    (oe_rise),
        .oe_q       (oe_q)
    );

    bytelane_row_col_unit #(.ADDR_W(ADDR_W)) u_rowcol (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_fall   (ras_fall),
        .ras_rise   (ras_rise),
        .cas_fall   (cas_fall),
        .cas_was_low(cas_was_low),
        .addr       (addr),
        .acc_open   (acc_open),
        .rfsh_busy  (rfsh_busy),
        .row_q      (row_q),
        .col_eff    (col_eff),
        .rfsh_cnt   (rfsh_row)
    );

    // Fold a full address onto a few index bits by XOR of its bit groups.
    function automatic logic [ROW_KEEP-1:0] fold_row(input logic [ADDR_W-1:0] v);
        logic [ROW_KEEP-1:0] f;
        f = '0;
        for (int i = 0; i < ADDR_W; i++) f[i % ROW_KEEP] ^= v[i];
        return f;
    endfunction

    function automatic logic [COL_KEEP-1:0] fold_col(input logic [ADDR_W-1:0] v);
        logic [COL_KEEP-1:0] f;
        f = '0;
        for (int i = 0; i < ADDR_W; i++) f[i % COL_KEEP] ^= v[i];
        return f;
    endfunction

    // Launch decisions for this edge.
    always_comb begin
        cas_low    = ~cas_n;
        lanes_live = {~ucas_n, ~lcas_n};
        rd_go   = acc_open && we_n && !oe_n && cas_low && (cas_fall || oe_fall);
        wr_cas  = acc_open && cas_fall && !we_n;
        wr_late = acc_open && we_fall && cas_low && !cas_fall;
        wr_go   = wr_cas || wr_late;
        if (wr_late || (wr_cas && wfirst && !we_fall)) wr_data = wcap;
        else                                          wr_data = din;
        wr_mask = wr_go ? lanes_live : '0;
        idx     = {fold_row(row_q), fold_col(col_eff)};
    end

    bytelane_lane_store #(.LANE_W(LANE_W), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .wr_mask(wr_mask),
        .idx    (idx),
        .wdata  (wr_data),
        .rdata  (rdata)
    );

    // Capture write data at whichever of WE fall / column fall comes first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcap   <= '0;
            wfirst <= 1'b0;
        end else begin
            if (acc_open && ((we_fall && !cas_low) || (cas_fall && we_n))) begin
                wcap <= din;
            end
            if (cas_fall || ras_rise)                     wfirst <= 1'b0;
            else if (acc_open && we_fall && !cas_low)     wfirst <= 1'b1;
        end
    end

    // Read data and per-lane drive, held across the column strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_drv <= '0;
            dq_out   <= '0;
        end else if (rd_go) begin
            lane_drv <= lanes_live;
            dq_out   <= rdata;
        end else if (cas_fall || wr_go || oe_rise || rfsh_busy || (ras_n && cas_n)) begin
            lane_drv <= '0;
        end
    end

    assign dq_oe = lane_drv & {LANES{~oe_q}};
endmodule

// File: rtl/bytelane_dram_chk.sv
// Module: property checker for bytelane_dram_core, attached by bind.
// Observes ports plus the refresh-busy flag of the row/column unit.
module bytelane_dram_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              lcas_n,
    input logic              ucas_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [1:0]        dq_oe,
    input logic [ADDR_W-1:0] rfsh_row,
    input logic              rfsh_busy
);
    // R3/R4: low lane turns on only after a launch with LCAS low, OE low, WE high.
    p_lane_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe[0]) |-> (!$past(lcas_n) && !$past(oe_n) && $past(we_n)));

    // R3/R4: high lane turns on only after a launch with UCAS low, OE low, WE high.
    p_lane_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe[1]) |-> (!$past(ucas_n) && !$past(oe_n) && $past(we_n)));

    // R8: nothing is driven while a refresh-only cycle is open.
    p_refresh_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_busy |-> (dq_oe == 2'b00));

    // R10: all strobes high turns every lane off at the next edge.
    p_idle_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && lcas_n && ucas_n) |=> (dq_oe == 2'b00));

    // R10: OE high turns every lane off at the next edge.
    p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (dq_oe == 2'b00));

    // R9: the refresh counter only ever steps by one (with wrap).
    p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(rfsh_row)) |-> (rfsh_row == ADDR_W'($past(rfsh_row) + 1'b1)));
endmodule

bind bytelane_dram_core bytelane_dram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .lcas_n   (lcas_n),
    .ucas_n   (ucas_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dq_oe    (dq_oe),
    .rfsh_row (rfsh_row),
    .rfsh_busy(rfsh_busy)
);

// File: tb/bytelane_dram_core_tb.sv
// Bench: vector table for the main access sequences, then directed tests for
// reset and refresh counter wrap.
module bytelane_dram_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [8:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic [8:0]  rfsh_row;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    bytelane_dram_core u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
        .dq_out(dq_out), .dq_oe(dq_oe), .rfsh_row(rfsh_row)
    );

    typedef struct packed {
        logic        r, l, u, w, o;
        logic [8:0]  a;
        logic [15:0] d;
        logic [1:0]  eo;
        logic [15:0] ed;
        logic [3:0]  rq;
    } vec_t;

    function automatic vec_t v(input int r, l, u, w, o, a, d, eo, ed, rq);
        vec_t t;
        t.r = r[0]; t.l = l[0]; t.u = u[0]; t.w = w[0]; t.o = o[0];
        t.a = a[8:0]; t.d = d[15:0]; t.eo = eo[1:0]; t.ed = ed[15:0]; t.rq = rq[3:0];
        return t;
    endfunction

    localparam int NV = 42;
    // Fields: ras lcas ucas we oe addr din | expected dq_oe, expected dq_out, requirement
    localparam vec_t VEC [NV] = '{
        v(1,1,1,1,1,0,'h0000,0,'h0000,10),   // R10 idle
        v(0,1,1,1,1,5,'h0000,0,'h0000,1),    // R1 row 5
        v(0,0,0,0,1,3,'hA5C3,0,'h0000,5),    // R5 early write col 3
        v(0,1,1,0,1,0,'h0000,0,'h0000,5),
        v(0,0,0,0,1,4,'h1234,0,'h0000,7),    // R7 page write col 4
        v(1,1,1,1,1,0,'h0000,0,'h0000,10),
        v(0,1,1,1,0,5,'h0000,0,'h0000,4),    // R4 OE low, no column yet
        v(0,0,0,1,0,3,'h0000,3,'hA5C3,1),    // R1 R4 read col 3
        v(0,1,1,1,0,0,'h0000,3,'hA5C3,6),    // R6 held after strobe rise
        v(0,0,0,1,0,4,'h0000,3,'h1234,7),    // R7 page read col 4
        v(0,1,1,1,0,0,'h0000,3,'h1234,6),    // R6
        v(0,0,1,1,0,3,'h0000,1,'hA5C3,2),    // R2 R3 low lane only
        v(0,0,1,1,1,3,'h0000,0,'h0000,10),   // R10 OE high
        v(0,0,1,1,0,3,'h0000,1,'hA5C3,4),    // R4 OE-launched read
        v(1,1,1,1,0,0,'h0000,0,'h0000,10),   // R10 all strobes high
        v(0,1,1,1,1,5,'h0000,0,'h0000,1),
        v(0,1,0,0,1,3,'hEEFF,0,'h0000,3),    // R2 R3 high-lane write
        v(1,1,1,1,1,0,'h0000,0,'h0000,10),
        v(0,1,1,1,1,5,'h0000,0,'h0000,1),
        v(0,0,0,1,1,4,'h7788,0,'h0000,5),    // R5 data at strobe fall
        v(0,0,0,0,1,4,'h0000,0,'h0000,5),    // R5 late write
        v(1,1,1,1,1,0,'h0000,0,'h0000,10),
        v(0,1,1,1,1,6,'h0000,0,'h0000,1),
        v(0,1,1,0,1,0,'h1111,0,'h0000,5),    // R5 WE first
        v(0,0,0,0,1,0,'h2222,0,'h0000,5),
        v(1,1,1,1,1,0,'h0000,0,'h0000,10),
        v(0,1,1,1,0,5,'h0000,0,'h0000,1),
        v(0,0,0,1,0,3,'h0000,3,'hEEC3,3),    // R3 only high byte replaced
        v(0,1,1,1,0,0,'h0000,3,'hEEC3,6),
        v(0,0,0,1,0,4,'h0000,3,'h7788,5),    // R5 late write data
        v(1,1,1,1,0,0,'h0000,0,'h0000,10),
        v(0,1,1,1,0,6,'h0000,0,'h0000,1),
        v(0,0,0,1,0,0,'h0000,3,'h1111,5),    // R5 WE-first data
        v(1,1,1,1,1,0,'h0000,0,'h0000,10),
        v(1,0,0,1,0,5,'h0000,0,'h0000,8),    // R8 strobe low before row strobe
        v(0,0,0,1,0,3,'h0000,0,'h0000,8),    // R8 refresh, outputs off
        v(0,1,1,0,0,3,'hDEAD,0,'h0000,8),
        v(0,0,0,0,0,3,'hBEEF,0,'h0000,8),    // R8 write attempt ignored
        v(1,1,1,1,1,0,'h0000,0,'h0000,9),
        v(0,1,1,1,0,5,'h0000,0,'h0000,1),
        v(0,0,0,1,0,3,'h0000,3,'hEEC3,8),    // R8 cell untouched by refresh
        v(1,1,1,1,1,0,'h0000,0,'h0000,10)
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, l, u, w, o, input logic [8:0] a, input logic [15:0] d);
        ras_n = r; lcas_n = l; ucas_n = u; we_n = w; oe_n = o; addr = a; din = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic refresh_once();
        drive(1, 0, 0, 1, 1, 9'h1FF, 16'h0); step();
        drive(0, 0, 0, 1, 1, 9'h1FF, 16'h0); step();
        drive(1, 1, 1, 1, 1, 9'h000, 16'h0); step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        step();
        check("R11 reset dq_oe", {30'd0, dq_oe}, 32'd0);
        check("R11 reset rfsh_row", {23'd0, rfsh_row}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].r, VEC[i].l, VEC[i].u, VEC[i].w, VEC[i].o, VEC[i].a, VEC[i].d);
            step();
            check($sformatf("R%0d vec%0d dq_oe", VEC[i].rq, i), {30'd0, dq_oe}, {30'd0, VEC[i].eo});
            if (VEC[i].eo != 2'b00)
                check($sformatf("R%0d vec%0d dq_out", VEC[i].rq, i), {16'd0, dq_out}, {16'd0, VEC[i].ed});
        end

        // R9: one refresh cycle in the table
        check("R9 count after one refresh", {23'd0, rfsh_row}, 32'd1);

        // R11: reset during a live read clears drive and counter
        drive(0, 1, 1, 1, 0, 9'd5, 16'h0); step();
        drive(0, 0, 0, 1, 0, 9'd3, 16'h0); step();
        check("R4 read before reset", {30'd0, dq_oe}, 32'd3);
        rst_n = 1'b0; step();
        check("R11 dq_oe in reset", {30'd0, dq_oe}, 32'd0);
        check("R11 rfsh_row in reset", {23'd0, rfsh_row}, 32'd0);
        rst_n = 1'b1;
        drive(1, 1, 1, 1, 1, 9'd0, 16'h0); step();
        check("R11 quiet after reset", {30'd0, dq_oe}, 32'd0);

        // R9: counter wrap 511 -> 0
        for (int k = 0; k < 511; k++) refresh_once();
        check("R9 count at 511", {23'd0, rfsh_row}, 32'd511);
        refresh_once();
        check("R9 wrap to 0", {23'd0, rfsh_row}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule